// File: doc/BRIEF.md
# Prescaled Match Timer

The block is a 32-bit up-counter with a programmable prescaler and four compare channels. The count is advanced by a tick. In clock mode a tick is every clock cycle. In the three pin modes a tick is a rising edge, a falling edge or either edge of one of the input pins. The pins pass through a two-flop synchronizer, and a field in the mode register selects which pin is used. The prescaler lets one count step through every (limit + 1) ticks.

Each compare channel holds a value. It also has its own options:
- zero the counter on the next step
- halt the counter by clearing the run bit
- contribute to the shared interrupt line
- apply an action to its own output bit: keep, drive low, drive high or invert

Software loads the output bits directly to set their starting levels. It reads and writes every register through a flat port. Writes are synchronous. Reads are combinational from `rd_addr`.

Top module: `match_timer`

## Requirements
- R1: After reset the count, prescale count, run bit, hold bit, flags, output bits and `irq` are all 0.
- R2: In clock mode (mode code 0) with the run bit (bit 0 of control, address 0) set and hold clear, the count rises by one every (P+1) cycles, where P is the prescale limit at address 2. Prescale 0 steps the count on every cycle. With the run bit clear the count does not move. The count is read at address 3 and the prescale count at address 4.
- R3: The mode register (address 1) holds the mode in bits 1:0 and the pin select in bits 3:2. Mode code 1 counts rising edges of the selected pin, code 2 counts falling edges and code 3 counts both. Edges on unselected pins have no effect.
- R4: While the hold bit (bit 1 of control) is set, the count and the prescale count are 0 from the next clock edge on. A hold never raises a compare event.
- R5: A compare event for channel k occurs when the count steps to a value equal to the channel's compare value (address 8+k). The event sets flag k (address 5, bit k).
- R6: Each channel has a 5-bit option field at bits 5k+4..5k of address 6. Bit 0 of the field enables the interrupt, bit 1 zeroes the counter, bit 2 halts the counter, and bits 4:3 hold the action. If bit 1 is set, the next count step after the count equals the compare value loads 0 instead of incrementing, which gives a cycle of (value+1) steps.
- R7: A compare event with the halt option clears the run bit on the same edge, so the count stays at the compare value.
- R8: On a compare event, output bit k follows action code 0 (keep), 1 (drive low), 2 (drive high) or 3 (invert). A write to address 7 loads all output bits directly.
- R9: Writing a 1 to flag bit k clears it. `irq` is 1 exactly when some flag is set whose interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational |
| cap_in | input | 4 | Asynchronous count input pins |
| match_out | output | 4 | Per-channel output bits |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a counter in a pin mode with the prescaler active. In that case each count step depends on the input edges passing through the synchronizer, so the cycle-exact timing cannot be seen. The stimulus drives slow pulse trains on the selected pin, or on a different pin for the ignored case, then lets the synchronizer settle before reading. The expected count therefore depends only on the number of edges and the prescale limit. Compare cases run free in clock mode and are sampled mid-run, so that zeroing, inverting and halting are checked at computed step counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CNT_CLK  = 2'd0,
        CNT_RISE = 2'd1,
        CNT_FALL = 2'd2,
        CNT_BOTH = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        EXT_KEEP = 2'd0,
        EXT_LOW  = 2'd1,
        EXT_HIGH = 2'd2,
        EXT_FLIP = 2'd3
    } ext_act_e;

    typedef struct packed {
        ext_act_e act;
        logic     halt;
        logic     zero;
        logic     irq_en;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    localparam int A_CTRL  = 0;
    localparam int A_MODE  = 1;
    localparam int A_PSC   = 2;
    localparam int A_COUNT = 3;
    localparam int A_PCNT  = 4;
    localparam int A_FLAG  = 5;
    localparam int A_CFG   = 6;
    localparam int A_OUT   = 7;
    localparam int A_CMP   = 8;

    function automatic logic ext_next(ext_act_e a, logic cur);
        case (a)
            EXT_LOW:  return 1'b0;
            EXT_HIGH: return 1'b1;
            EXT_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel
    import tmr_pkg::*;
#(
    parameter int N_CAP = 4,
    localparam int SEL_W = (N_CAP > 1) ? $clog2(N_CAP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CAP-1:0] pins,
    input  logic [SEL_W-1:0] sel,
    input  cnt_mode_e        mode,
    output logic             tick
);
    logic [N_CAP-1:0] s1, s2, s3;
    logic cur, old;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= pins;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign cur = s2[sel];
    assign old = s3[sel];

    always_comb begin
        case (mode)
            CNT_RISE: tick = cur & ~old;
            CNT_FALL: tick = ~cur & old;
            CNT_BOTH: tick = cur ^ old;
            default:  tick = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr_prescale_count.sv
module tmr_prescale_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             tick,
    input  logic             zero_req,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] pcount,
    output logic [CNT_W-1:0] count_nx,
    output logic             step
);
    logic [CNT_W-1:0] pcount_nx;

    always_comb begin
        count_nx  = count;
        pcount_nx = pcount;
        step      = 1'b0;
        if (hold) begin
            count_nx  = '0;
            pcount_nx = '0;
        end else if (tick) begin
            if (pcount >= limit) begin
                pcount_nx = '0;
                step      = 1'b1;
                count_nx  = zero_req ? '0 : count + 1'b1;
            end else begin
                pcount_nx = pcount + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            pcount <= '0;
        end else begin
            count  <= count_nx;
            pcount <= pcount_nx;
        end
    end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CNT_W-1:0]           count,
    input  logic [CNT_W-1:0]           count_nx,
    input  logic                       step,
    input  logic [N_MATCH*CNT_W-1:0]   cmp_flat,
    input  logic [N_MATCH*CFG_W-1:0]   cfg_flat,
    input  logic                       out_wr,
    input  logic [N_MATCH-1:0]         out_wdata,
    output logic [N_MATCH-1:0]         hit,
    output logic [N_MATCH-1:0]         irq_en,
    output logic                       zero_req,
    output logic                       halt_req,
    output logic [N_MATCH-1:0]         ext_q
);
    logic [N_MATCH-1:0] zero_v, halt_v;

    for (genvar k = 0; k < N_MATCH; k++) begin : g_ch
        chan_cfg_t        c;
        logic [CNT_W-1:0] v;
        assign c         = chan_cfg_t'(cfg_flat[k*CFG_W +: CFG_W]);
        assign v         = cmp_flat[k*CNT_W +: CNT_W];
        assign hit[k]    = step && (count_nx == v);
        assign zero_v[k] = c.zero && (count == v);
        assign halt_v[k] = c.halt && hit[k];
        assign irq_en[k] = c.irq_en;

        always_ff @(posedge clk) begin
            if (rst)
                ext_q[k] <= 1'b0;
            else if (out_wr)
                ext_q[k] <= out_wdata[k];
            else if (hit[k])
                ext_q[k] <= ext_next(c.act, ext_q[k]);
        end
    end

    assign zero_req = |zero_v;
    assign halt_req = |halt_v;
endmodule

// File: rtl/match_timer.sv
module match_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 4,
    parameter int ADDR_W  = 4,
    localparam int SEL_W  = (N_CAP > 1) ? $clog2(N_CAP) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    input  logic [N_CAP-1:0]   cap_in,
    output logic [N_MATCH-1:0] match_out,
    output logic               irq
);
    logic                     run_q, hold_q;
    cnt_mode_e                mode_q;
    logic [SEL_W-1:0]         sel_q;
    logic [CNT_W-1:0]         psc_q;
    logic [N_MATCH*CNT_W-1:0] cmp_flat;
    logic [N_MATCH*CFG_W-1:0] cfg_flat;
    logic [N_MATCH-1:0]       flag_q, hit, irq_en;
    logic [CNT_W-1:0]         tc_val, pc_val, tc_nx;
    logic                     tick, step, zero_req, stop_fire;

    tmr_edge_sel #(.N_CAP(N_CAP)) u_edge (
        .clk(clk), .rst(rst), .pins(cap_in), .sel(sel_q),
        .mode(mode_q), .tick(tick)
    );

    tmr_prescale_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .hold(hold_q), .tick(tick & run_q),
        .zero_req(zero_req), .limit(psc_q), .count(tc_val),
        .pcount(pc_val), .count_nx(tc_nx), .step(step)
    );

    tmr_match_unit #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match (
        .clk(clk), .rst(rst), .count(tc_val), .count_nx(tc_nx),
        .step(step), .cmp_flat(cmp_flat), .cfg_flat(cfg_flat),
        .out_wr(wr_en && wr_addr == ADDR_W'(A_OUT)),
        .out_wdata(wr_data[N_MATCH-1:0]), .hit(hit), .irq_en(irq_en),
        .zero_req(zero_req), .halt_req(stop_fire), .ext_q(match_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            hold_q   <= 1'b0;
            mode_q   <= CNT_CLK;
            sel_q    <= '0;
            psc_q    <= '0;
            cmp_flat <= '0;
            cfg_flat <= '0;
            flag_q   <= '0;
        end else begin
            if (stop_fire)
                run_q <= 1'b0;
            else if (wr_en && wr_addr == ADDR_W'(A_CTRL))
                run_q <= wr_data[0];
            if (wr_en && wr_addr == ADDR_W'(A_CTRL))
                hold_q <= wr_data[1];
            if (wr_en && wr_addr == ADDR_W'(A_MODE)) begin
                mode_q <= cnt_mode_e'(wr_data[1:0]);
                sel_q  <= wr_data[2 +: SEL_W];
            end
            if (wr_en && wr_addr == ADDR_W'(A_PSC))
                psc_q <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(A_CFG))
                cfg_flat <= wr_data[N_MATCH*CFG_W-1:0];
            for (int k = 0; k < N_MATCH; k++)
                if (wr_en && wr_addr == ADDR_W'(A_CMP + k))
                    cmp_flat[k*CNT_W +: CNT_W] <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(A_FLAG))
                flag_q <= (flag_q & ~wr_data[N_MATCH-1:0]) | hit;
            else
                flag_q <= flag_q | hit;
        end
    end

    assign irq = |(flag_q & irq_en);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL):  rd_data[1:0] = {hold_q, run_q};
            ADDR_W'(A_MODE):  rd_data[2+SEL_W-1:0] = {sel_q, mode_q};
            ADDR_W'(A_PSC):   rd_data = psc_q;
            ADDR_W'(A_COUNT): rd_data = tc_val;
            ADDR_W'(A_PCNT):  rd_data = pc_val;
            ADDR_W'(A_FLAG):  rd_data[N_MATCH-1:0] = flag_q;
            ADDR_W'(A_CFG):   rd_data[N_MATCH*CFG_W-1:0] = cfg_flat;
            ADDR_W'(A_OUT):   rd_data[N_MATCH-1:0] = match_out;
            default: begin
                for (int k = 0; k < N_MATCH; k++)
                    if (rd_addr == ADDR_W'(A_CMP + k))
                        rd_data = cmp_flat[k*CNT_W +: CNT_W];
            end
        endcase
    end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     run_q,
    input logic                     hold_q,
    input logic                     stop_fire,
    input logic                     irq,
    input logic [CNT_W-1:0]         tc_val,
    input logic [N_MATCH-1:0]       flag_q,
    input logic [N_MATCH*CNT_W-1:0] cmp_flat
);
    // R4
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |=> (tc_val == '0));

    // R2
    idle_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !hold_q) |=> $stable(tc_val));

    // R7
    halt_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
        stop_fire |=> !run_q);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_q != '0));

    for (genvar k = 0; k < N_MATCH; k++) begin : g_flag
        // R5
        flag_on_match_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[k]) |-> (tc_val == cmp_flat[k*CNT_W +: CNT_W]));
    end
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (
    .clk(clk), .rst(rst), .run_q(run_q), .hold_q(hold_q),
    .stop_fire(stop_fire), .irq(irq), .tc_val(tc_val),
    .flag_q(flag_q), .cmp_flat(cmp_flat)
);

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
    logic        clk = 0, rst = 1;
    logic        wr_en = 0;
    logic [3:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic [3:0]  cap_in = 0, match_out;
    logic        irq;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    match_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .match_out(match_out), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        rd_addr = 4'(a);
        #0.5;
        d = rd_data;
    endtask

    task automatic clr();
        wr(0, 2);
        wr(0, 0);
    endtask

    task automatic pulses(int pin, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cap_in[pin] = 1;
            repeat (4) @(negedge clk);
            cap_in[pin] = 0;
            repeat (3) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    function automatic int steps(int ev, int p);
        return ev / (p + 1);
    endfunction

    task automatic clk_run(int p, int k);
        logic [31:0] v;
        wr(2, p); clr(); wr(0, 1);
        repeat (k) @(negedge clk);
        rd(3, v);
        chk("R2 clock-mode count", v, steps(k, p));
        wr(0, 0);
    endtask

    task automatic pin_run(int mode, int sel, int pin, int p, int n);
        logic [31:0] v;
        int ev;
        wr(1, (sel << 2) | mode); wr(2, p); clr(); wr(0, 1);
        pulses(pin, n);
        rd(3, v);
        ev = (pin != sel) ? 0 : (mode == 3 ? 2 * n : n);
        chk("R3 pin-mode count", v, steps(ev, p));
        wr(0, 0);
        wr(1, 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd(3, v); chk("R1 count", v, 0);
        rd(4, v); chk("R1 pcount", v, 0);
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(5, v); chk("R1 flags", v, 0);
        chk("R1 outputs", {28'd0, match_out}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        for (int k = 0; k < 4; k++) wr(8 + k, 32'hFFFF_0000);

        // R2 directed and random
        clk_run(0, 13);
        clk_run(3, 21);
        wr(2, 0); clr(); wr(0, 1); wr(0, 0);
        rd(3, v);
        repeat (10) @(negedge clk);
        begin
            logic [31:0] v2;
            rd(3, v2);
            chk("R2 stopped count holds", v2, v);
        end
        for (int i = 0; i < 5; i++) clk_run($urandom % 4, $urandom % 40);

        // R3 pin modes
        pin_run(1, 2, 2, 0, 5);
        pin_run(2, 1, 1, 1, 6);
        pin_run(3, 3, 3, 0, 3);
        pin_run(1, 0, 3, 0, 4);
        for (int i = 0; i < 3; i++)
            pin_run(1 + ($urandom % 3), 1, 1, $urandom % 3, 1 + ($urandom % 5));

        // R4 hold
        wr(2, 2); wr(0, 3);
        repeat (10) @(negedge clk);
        rd(3, v); chk("R4 count held at 0", v, 0);
        rd(4, v); chk("R4 pcount held at 0", v, 0);
        wr(0, 1);
        repeat (9) @(negedge clk);
        rd(3, v); chk("R4 count after release", v, 3);
        wr(0, 0);

        // R6 zero-on-match with invert action, R5 flags, R9 irq
        wr(2, 0); wr(5, 32'hF); wr(7, 0);
        wr(8, 5); wr(6, 32'b11011);
        clr(); wr(0, 1);
        repeat (8) @(negedge clk);
        rd(3, v); chk("R6 count wraps after 8 steps", v, 2);
        chk("R8 invert after 1 event", {28'd0, match_out}, 1);
        repeat (9) @(negedge clk);
        rd(3, v); chk("R6 count wraps after 17 steps", v, 5);
        chk("R8 invert after 3 events", {28'd0, match_out}, 1);
        rd(5, v); chk("R5 flag 0 set", v, 1);
        chk("R9 irq raised", {31'd0, irq}, 1);
        wr(0, 0); wr(5, 1);
        rd(5, v); chk("R9 flag cleared by write-one", v, 0);
        chk("R9 irq dropped", {31'd0, irq}, 0);

        // R7 halt on match
        wr(8, 32'hFFFF_0000); wr(9, 7); wr(6, 32'b00100 << 5);
        clr(); wr(0, 1);
        repeat (20) @(negedge clk);
        rd(3, v); chk("R7 count stays at compare value", v, 7);
        rd(0, v); chk("R7 run bit cleared", v, 0);
        rd(5, v); chk("R5 flag 1 set", v, 2);

        // R8 actions, R9 enables
        wr(5, 32'hF); wr(9, 2); wr(10, 3); wr(11, 4);
        wr(6, (32'd16 << 10) | (32'd8 << 15));
        wr(7, 4'b1010);
        chk("R8 direct output load", {28'd0, match_out}, 4'b1010);
        clr(); wr(0, 1);
        repeat (10) @(negedge clk);
        chk("R8 keep/high/low actions", {28'd0, match_out}, 4'b0110);
        rd(5, v); chk("R5 flags 1..3", v, 4'b1110);
        chk("R9 irq off without enables", {31'd0, irq}, 0);
        wr(0, 0);
        wr(6, (32'd16 << 10) | (32'd8 << 15) | (32'd1 << 10));
        chk("R9 irq on with enable", {31'd0, irq}, 1);
        wr(5, 4'b0100);
        rd(5, v); chk("R9 selective clear", v, 4'b1010);
        chk("R9 irq off after clear", {31'd0, irq}, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule